// File: doc/BRIEF.md
# Register Wakeup Tracker

This block follows the readiness of the tracked physical registers of an out-of-order core and remembers which waiting instructions need each register. An instruction is entered by tag together with its source and destination register indices and a per-source "already ready" flag. Sources that cannot be satisfied at once are linked to the register they wait on, using nodes taken from a shared pool. When a producer finishes, its destination registers are named on the completion port. The block then visits the linked waiters one per clock, marks the matching source ready, and finally sets the scoreboard bits of those registers.

Tags whose sources are all ready leave on a one-per-cycle ready stream and free their table entry. A squash drops a tag and returns its link nodes to the pool. Register indices at or above the tracked count are never waited on and never written. The instruction payload and issue selection live elsewhere.

Top module: `sb_wakeup_tracker`

## Requirements
- R1: After reset the outputs rdy_valid, busy, pool_low and err_prod are low and every tracked register reads not-ready, so a tracked source without its ready flag keeps its instruction waiting.
- R2: A source whose ready flag is set, or whose index is at or above NUM_REGS, never blocks; an instruction with only such sources is presented on rdy_valid/rdy_tag one clock after the insert is registered.
- R3: Once a completion of a register has drained, a later source naming that register is ready at insert without its flag.
- R4: An insert clears the scoreboard bit of each of its destinations below NUM_REGS, so a later unflagged consumer of that register waits.
- R5: A completion accepted while busy is low that names a tracked register with n linked waiters raises busy in the next cycle and keeps it high for exactly n+1 cycles, one waiter visited per cycle.
- R6: Destination indices at or above NUM_REGS are ignored; a completion naming only such indices leaves busy low.
- R7: A tag is reported only when all of its sources are ready; each wakeup marks exactly one source of a waiter, so a tag waiting on two registers needs both completions.
- R8: Every tag that becomes fully ready is reported exactly once, at most one tag per cycle, in the order readiness was reached when readiness events are spread over distinct cycles.
- R9: A squashed tag is never reported and all its link nodes go back to the pool at once.
- R10: pool_low is high exactly while fewer than NUM_SRC link nodes are free; the caller holds inserts while it is high.
- R11: err_prod pulses for one cycle after an insert whose tracked destination still has a non-empty waiter list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert strobe |
| ins_tag | input | TAG_W | Tag of the inserted instruction (must be free) |
| ins_src | input | NUM_SRC*IDX_W | Source indices, source s at bits s*IDX_W |
| ins_src_rdy | input | NUM_SRC | Per-source already-ready flags |
| ins_dst | input | NUM_DST*IDX_W | Destination indices, destination d at bits d*IDX_W |
| cmp_valid | input | 1 | Completion strobe, honoured while busy is low |
| cmp_dst | input | NUM_DST*IDX_W | Registers written by the finishing producer |
| sq_valid | input | 1 | Squash strobe |
| sq_tag | input | TAG_W | Tag to drop |
| rdy_valid | output | 1 | A tag became fully ready |
| rdy_tag | output | TAG_W | The ready tag |
| busy | output | 1 | A completion is being drained |
| pool_low | output | 1 | Fewer than NUM_SRC link nodes free |
| err_prod | output | 1 | Producer inserted over a non-empty waiter list |

## Verification
The bench builds the block with 16 tracked registers behind 5-bit indices, 8 tags, two sources, two destinations and only six link nodes. The 5-bit index reaches the untracked range 16 to 31 on both insert and completion, and six nodes let three inserts exhaust the pool so the low flag, its release by squash and node reuse after a drain are all reached. Two sources per tag make partial wakeup visible: one completion leaves a tag waiting on the other register.

// File: rtl/sb_pkg.sv
// Shared constants and helpers for the register wakeup tracker.
package sb_pkg;
    localparam int SB_REGS_DEF  = 64;
    localparam int SB_IDXW_DEF  = 7;
    localparam int SB_TAGS_DEF  = 32;
    localparam int SB_SRC_DEF   = 2;
    localparam int SB_DST_DEF   = 1;
    localparam int SB_NODES_DEF = 24;

    // Index width for n items, never below one bit.
    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/sb_reg_state.sv
// Per-register scoreboard and completion drain control.
// Holds one ready bit per tracked register and the mask of registers whose
// waiters are being woken. Assumes cmp_valid is only honoured while idle.
module sb_reg_state #(
    parameter int NUM_REGS = 64,
    parameter int IDX_W    = 7,
    parameter int NUM_DST  = 1,
    parameter int PW       = sb_pkg::width_of(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ins_valid,
    input  logic [NUM_DST*IDX_W-1:0] ins_dst,
    input  logic                     cmp_valid,
    input  logic [NUM_DST*IDX_W-1:0] cmp_dst,
    input  logic                     walk_hit,
    input  logic [NUM_REGS-1:0]      list_ne,
    output logic [NUM_REGS-1:0]      sb_eff,
    output logic [NUM_REGS-1:0]      wmask,
    output logic                     busy,
    output logic                     err_prod
);
    logic [NUM_REGS-1:0] sb_q;
    logic [NUM_REGS-1:0] ins_dmask;
    logic [NUM_REGS-1:0] cmp_dmask;
    logic [NUM_REGS-1:0] ins_clr;
    logic                finishing;

    // Decode in-range destination indices into register masks.
    always_comb begin
        ins_dmask = '0;
        cmp_dmask = '0;
        for (int d = 0; d < NUM_DST; d++) begin
            if (int'(ins_dst[d*IDX_W +: IDX_W]) < NUM_REGS)
                ins_dmask[ins_dst[d*IDX_W +: PW]] = 1'b1;
            if (int'(cmp_dst[d*IDX_W +: IDX_W]) < NUM_REGS)
                cmp_dmask[cmp_dst[d*IDX_W +: PW]] = 1'b1;
        end
    end

    assign busy      = |wmask;
    assign finishing = busy & ~walk_hit;
    assign ins_clr   = ins_valid ? ins_dmask : '0;
    // A register finishing this cycle already counts as ready for inserts.
    assign sb_eff    = sb_q | (finishing ? wmask : '0);

    // Scoreboard, drain mask and producer-conflict flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_q     <= '0;
            wmask    <= '0;
            err_prod <= 1'b0;
        end else begin
            sb_q     <= sb_eff & ~ins_clr;
            err_prod <= |(ins_clr & list_ne);
            if (finishing)
                wmask <= '0;
            else if (cmp_valid && !busy)
                wmask <= cmp_dmask;
        end
    end
endmodule

// File: rtl/sb_link_pool.sv
// Shared pool of waiter link nodes.
// Each node names the register waited on, the waiting tag and its source
// slot. A register's waiter list is the set of live nodes naming it. Nodes
// are allocated lowest-first, freed by the drain walk or by a tag squash.
module sb_link_pool #(
    parameter int NUM_REGS  = 64,
    parameter int NUM_NODES = 24,
    parameter int NUM_SRC   = 2,
    parameter int TAG_W     = 5,
    parameter int PW        = sb_pkg::width_of(NUM_REGS),
    parameter int SW        = sb_pkg::width_of(NUM_SRC),
    parameter int NW        = sb_pkg::width_of(NUM_NODES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     alloc_req,
    input  logic [NUM_SRC*PW-1:0]  alloc_reg,
    input  logic [TAG_W-1:0]       alloc_tag,
    input  logic                   sq_valid,
    input  logic [TAG_W-1:0]       sq_tag,
    input  logic [NUM_REGS-1:0]    wmask,
    output logic                   walk_hit,
    output logic [TAG_W-1:0]       walk_tag,
    output logic [SW-1:0]          walk_slot,
    output logic [NUM_REGS-1:0]    list_ne,
    output logic                   pool_low
);
    logic [NUM_NODES-1:0] n_vld;
    logic [PW-1:0]        n_reg  [NUM_NODES];
    logic [TAG_W-1:0]     n_tag  [NUM_NODES];
    logic [SW-1:0]        n_slot [NUM_NODES];

    logic [NUM_NODES-1:0] grant;
    logic [SW-1:0]        gslot  [NUM_NODES];
    logic [NUM_SRC-1:0]   taken;
    logic                 found;
    logic [NW-1:0]        walk_idx;
    int                   free_cnt;

    // Hand free nodes to requesting sources, lowest node and slot first.
    always_comb begin
        grant = '0;
        taken = '0;
        found = 1'b0;
        for (int n = 0; n < NUM_NODES; n++) begin
            gslot[n] = '0;
            found    = 1'b0;
            if (!n_vld[n]) begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (!found && alloc_req[s] && !taken[s]) begin
                        grant[n] = 1'b1;
                        gslot[n] = SW'(s);
                        taken[s] = 1'b1;
                        found    = 1'b1;
                    end
                end
            end
        end
    end

    // Pick the lowest live node waiting on a register being drained.
    always_comb begin
        walk_hit  = 1'b0;
        walk_idx  = '0;
        walk_tag  = '0;
        walk_slot = '0;
        for (int n = NUM_NODES - 1; n >= 0; n--) begin
            if (n_vld[n] && wmask[n_reg[n]]) begin
                walk_hit  = 1'b1;
                walk_idx  = NW'(n);
                walk_tag  = n_tag[n];
                walk_slot = n_slot[n];
            end
        end
    end

    // Waiter-list occupancy per register and free-node count.
    always_comb begin
        list_ne  = '0;
        free_cnt = 0;
        for (int n = 0; n < NUM_NODES; n++) begin
            if (n_vld[n]) list_ne[n_reg[n]] = 1'b1;
            else          free_cnt = free_cnt + 1;
        end
    end

    assign pool_low = (free_cnt < NUM_SRC);

    // Node storage: fill on grant, free on walk or squash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_vld <= '0;
            for (int n = 0; n < NUM_NODES; n++) begin
                n_reg[n]  <= '0;
                n_tag[n]  <= '0;
                n_slot[n] <= '0;
            end
        end else begin
            for (int n = 0; n < NUM_NODES; n++) begin
                if (grant[n]) begin
                    n_vld[n]  <= 1'b1;
                    n_reg[n]  <= alloc_reg[gslot[n]*PW +: PW];
                    n_tag[n]  <= alloc_tag;
                    n_slot[n] <= gslot[n];
                end else if (n_vld[n] && ((sq_valid && n_tag[n] == sq_tag) ||
                                          (walk_hit && walk_idx == NW'(n)))) begin
                    n_vld[n] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sb_tag_table.sv
// Per-tag source readiness and the ready stream.
// Tracks which sources of each live tag are satisfied, reports the lowest
// fully ready tag each cycle and frees it. Assumes inserts use free tags.
module sb_tag_table #(
    parameter int NUM_TAGS = 32,
    parameter int NUM_SRC  = 2,
    parameter int TAG_W    = 5,
    parameter int SW       = sb_pkg::width_of(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    input  logic [TAG_W-1:0]   ins_tag,
    input  logic [NUM_SRC-1:0] ins_rdy,
    input  logic               walk_hit,
    input  logic [TAG_W-1:0]   walk_tag,
    input  logic [SW-1:0]      walk_slot,
    input  logic               sq_valid,
    input  logic [TAG_W-1:0]   sq_tag,
    output logic               rdy_valid,
    output logic [TAG_W-1:0]   rdy_tag
);
    logic [NUM_TAGS-1:0] t_vld;
    logic [NUM_SRC-1:0]  t_rdy [NUM_TAGS];
    logic                sel_hit;
    logic [TAG_W-1:0]    sel_idx;

    // Choose the lowest live, fully ready tag not being squashed now.
    always_comb begin
        sel_hit = 1'b0;
        sel_idx = '0;
        for (int t = NUM_TAGS - 1; t >= 0; t--) begin
            if (t_vld[t] && (&t_rdy[t]) && !(sq_valid && sq_tag == TAG_W'(t))) begin
                sel_hit = 1'b1;
                sel_idx = TAG_W'(t);
            end
        end
    end

    // Tag state updates and the registered ready output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_vld     <= '0;
            rdy_valid <= 1'b0;
            rdy_tag   <= '0;
            for (int t = 0; t < NUM_TAGS; t++) t_rdy[t] <= '0;
        end else begin
            rdy_valid <= sel_hit;
            rdy_tag   <= sel_idx;
            for (int t = 0; t < NUM_TAGS; t++) begin
                if (ins_valid && ins_tag == TAG_W'(t)) begin
                    t_vld[t] <= 1'b1;
                    t_rdy[t] <= ins_rdy;
                end else begin
                    if ((sel_hit && sel_idx == TAG_W'(t)) ||
                        (sq_valid && sq_tag == TAG_W'(t)))
                        t_vld[t] <= 1'b0;
                    if (walk_hit && walk_tag == TAG_W'(t))
                        t_rdy[t][walk_slot] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sb_wakeup_tracker.sv
// Register wakeup tracker top.
// Resolves each inserted source against its flag, the index range and the
// scoreboard, links unresolved sources into the node pool, and drains a
// completion one waiter per cycle. Assumes the caller holds inserts while
// pool_low is high and completions while busy is high.
module sb_wakeup_tracker #(
    parameter int NUM_REGS  = sb_pkg::SB_REGS_DEF,
    parameter int IDX_W     = sb_pkg::SB_IDXW_DEF,
    parameter int NUM_TAGS  = sb_pkg::SB_TAGS_DEF,
    parameter int NUM_SRC   = sb_pkg::SB_SRC_DEF,
    parameter int NUM_DST   = sb_pkg::SB_DST_DEF,
    parameter int NUM_NODES = sb_pkg::SB_NODES_DEF,
    parameter int TAG_W     = sb_pkg::width_of(NUM_TAGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ins_valid,
    input  logic [TAG_W-1:0]         ins_tag,
    input  logic [NUM_SRC*IDX_W-1:0] ins_src,
    input  logic [NUM_SRC-1:0]       ins_src_rdy,
    input  logic [NUM_DST*IDX_W-1:0] ins_dst,
    input  logic                     cmp_valid,
    input  logic [NUM_DST*IDX_W-1:0] cmp_dst,
    input  logic                     sq_valid,
    input  logic [TAG_W-1:0]         sq_tag,
    output logic                     rdy_valid,
    output logic [TAG_W-1:0]         rdy_tag,
    output logic                     busy,
    output logic                     pool_low,
    output logic                     err_prod
);
    localparam int PW = sb_pkg::width_of(NUM_REGS);
    localparam int SW = sb_pkg::width_of(NUM_SRC);

    logic [NUM_REGS-1:0]   sb_eff;
    logic [NUM_REGS-1:0]   wmask;
    logic [NUM_REGS-1:0]   list_ne;
    logic [NUM_SRC-1:0]    src_now;
    logic [NUM_SRC-1:0]    alloc_req;
    logic [NUM_SRC*PW-1:0] alloc_reg;
    logic                  walk_hit;
    logic [TAG_W-1:0]      walk_tag;
    logic [SW-1:0]         walk_slot;

    // Per-source resolution: flag, untracked index, or scoreboard hit.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic [IDX_W-1:0] idx;
        logic             in_range;
        assign idx       = ins_src[s*IDX_W +: IDX_W];
        assign in_range  = (int'(idx) < NUM_REGS);
        assign src_now[s]   = ins_src_rdy[s] | ~in_range | sb_eff[idx[PW-1:0]];
        assign alloc_req[s] = ins_valid & ~src_now[s];
        assign alloc_reg[s*PW +: PW] = idx[PW-1:0];
    end

    sb_reg_state #(
        .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_DST(NUM_DST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_dst(ins_dst),
        .cmp_valid(cmp_valid), .cmp_dst(cmp_dst),
        .walk_hit(walk_hit), .list_ne(list_ne),
        .sb_eff(sb_eff), .wmask(wmask), .busy(busy), .err_prod(err_prod)
    );

    sb_link_pool #(
        .NUM_REGS(NUM_REGS), .NUM_NODES(NUM_NODES), .NUM_SRC(NUM_SRC), .TAG_W(TAG_W)
    ) u_pool (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_reg(alloc_reg), .alloc_tag(ins_tag),
        .sq_valid(sq_valid), .sq_tag(sq_tag), .wmask(wmask),
        .walk_hit(walk_hit), .walk_tag(walk_tag), .walk_slot(walk_slot),
        .list_ne(list_ne), .pool_low(pool_low)
    );

    sb_tag_table #(
        .NUM_TAGS(NUM_TAGS), .NUM_SRC(NUM_SRC), .TAG_W(TAG_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_rdy(src_now),
        .walk_hit(walk_hit), .walk_tag(walk_tag), .walk_slot(walk_slot),
        .sq_valid(sq_valid), .sq_tag(sq_tag),
        .rdy_valid(rdy_valid), .rdy_tag(rdy_tag)
    );
endmodule

// File: rtl/sb_wakeup_checker.sv
// Port-level properties of the wakeup tracker, bound to its top.
module sb_wakeup_checker #(
    parameter int NUM_REGS = 64,
    parameter int IDX_W    = 7,
    parameter int NUM_DST  = 1,
    parameter int TAG_W    = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ins_valid,
    input logic                     cmp_valid,
    input logic [NUM_DST*IDX_W-1:0] cmp_dst,
    input logic                     sq_valid,
    input logic [TAG_W-1:0]         sq_tag,
    input logic                     rdy_valid,
    input logic [TAG_W-1:0]         rdy_tag,
    input logic                     busy,
    input logic                     err_prod
);
    logic cmp_trk;

    // Does the completion name any tracked register?
    always_comb begin
        cmp_trk = 1'b0;
        for (int d = 0; d < NUM_DST; d++)
            if (int'(cmp_dst[d*IDX_W +: IDX_W]) < NUM_REGS) cmp_trk = 1'b1;
    end

    AST_CMP_STARTS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && !busy && cmp_trk |=> busy); // R5
    AST_UNTRACKED_CMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && !busy && !cmp_trk |=> !busy); // R6
    AST_ERR_FOLLOWS_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        err_prod |-> $past(ins_valid)); // R11
    AST_NO_REPEAT_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_valid |=> !(rdy_valid && rdy_tag == $past(rdy_tag))); // R8
    AST_SQUASH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> !(rdy_valid && rdy_tag == $past(sq_tag))); // R9
endmodule

bind sb_wakeup_tracker sb_wakeup_checker #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_DST(NUM_DST), .TAG_W(TAG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .cmp_valid(cmp_valid),
    .cmp_dst(cmp_dst), .sq_valid(sq_valid), .sq_tag(sq_tag),
    .rdy_valid(rdy_valid), .rdy_tag(rdy_tag), .busy(busy), .err_prod(err_prod)
);

// File: tb/tb_sb_wakeup_tracker.sv
module tb_sb_wakeup_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 16;
    localparam int IW    = 5;
    localparam int NTAG  = 8;
    localparam int TW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_valid = 1'b0;
    logic [TW-1:0] ins_tag = '0;
    logic [2*IW-1:0] ins_src = '0;
    logic [1:0]    ins_src_rdy = '0;
    logic [2*IW-1:0] ins_dst = '0;
    logic          cmp_valid = 1'b0;
    logic [2*IW-1:0] cmp_dst = '0;
    logic          sq_valid = 1'b0;
    logic [TW-1:0] sq_tag = '0;
    logic          rdy_valid, busy, pool_low, err_prod;
    logic [TW-1:0] rdy_tag;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sb_wakeup_tracker #(
        .NUM_REGS(NREG), .IDX_W(IW), .NUM_TAGS(NTAG), .NUM_SRC(2),
        .NUM_DST(2), .NUM_NODES(6), .TAG_W(TW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_tag(ins_tag),
        .ins_src(ins_src), .ins_src_rdy(ins_src_rdy), .ins_dst(ins_dst),
        .cmp_valid(cmp_valid), .cmp_dst(cmp_dst), .sq_valid(sq_valid),
        .sq_tag(sq_tag), .rdy_valid(rdy_valid), .rdy_tag(rdy_tag),
        .busy(busy), .pool_low(pool_low), .err_prod(err_prod)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: one-cycle insert; pushes the tag when it must be ready at once.
    task automatic ins(input int tag, input int s0, input int s1, input int rf,
                       input int d0, input int d1, input bit exp_rdy);
        @(negedge clk);
        ins_valid   = 1'b1;
        ins_tag     = TW'(tag);
        ins_src     = {IW'(s1), IW'(s0)};
        ins_src_rdy = 2'(rf);
        ins_dst     = {IW'(d1), IW'(d0)};
        if (exp_rdy) exp_q.push_back(tag);
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic cmp(input int d0, input int d1);
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_dst   = {IW'(d1), IW'(d0)};
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic squash(input int tag);
        @(negedge clk);
        sq_valid = 1'b1;
        sq_tag   = TW'(tag);
        @(negedge clk);
        sq_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Monitor: every reported tag must be the next expected one (R8).
    always @(negedge clk) begin
        if (rst_n && rdy_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R8: actual tag %0d expected no report", rdy_tag);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(rdy_tag) != e) begin
                    fails++;
                    $display("FAIL R8: actual tag %0d expected %0d", rdy_tag, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int cnt;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset.
        chk(!rdy_valid && !busy && !pool_low && !err_prod, "R1 idle",
            {rdy_valid, busy, pool_low, err_prod}, 0);

        // R2: untracked sources, reported one clock after the insert registers.
        ins(0, 20, 21, 0, 16, 31, 1'b1);
        chk(!rdy_valid, "R2 not yet", rdy_valid, 0);
        @(negedge clk);
        chk(rdy_valid && rdy_tag == 0, "R2 timing", rdy_valid, 1);
        // R2: flagged tracked source plus untracked source.
        ins(1, 3, 25, 1, 1, 20, 1'b1);
        idle(3);

        // R1: unflagged tracked sources wait on a reset scoreboard.
        ins(2, 1, 2, 0, 20, 20, 1'b0);
        cnt = 0;
        repeat (3) begin
            if (rdy_valid) cnt++;
            @(negedge clk);
        end
        chk(cnt == 0, "R1 waits", cnt, 0);

        // R10: pool fills.
        ins(3, 1, 20, 0, 20, 20, 1'b0);
        chk(!pool_low, "R10 three free", pool_low, 0);
        ins(4, 2, 1, 0, 20, 20, 1'b0);
        chk(pool_low, "R10 one free", pool_low, 1);

        // R9: squash frees nodes, tag never reported.
        squash(4);
        chk(!pool_low, "R9 nodes back", pool_low, 0);

        // R5/R7: drain reg1 with two waiters; tag3 done, tag2 still on reg2.
        exp_q.push_back(3);
        cmp(1, 31);
        cnt = 0;
        while (busy && cnt < 50) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 3, "R5 busy length", cnt, 3);
        idle(2);

        // R3: drained register is ready at insert.
        ins(5, 1, 20, 0, 20, 20, 1'b1);
        idle(3);

        // R4: new producer of reg1 makes later consumers wait.
        ins(6, 20, 20, 0, 1, 20, 1'b1);
        chk(!err_prod, "R11 empty list", err_prod, 0);
        idle(3);
        ins(7, 1, 20, 0, 20, 20, 1'b0);
        cnt = 0;
        repeat (3) begin
            if (rdy_valid) cnt++;
            @(negedge clk);
        end
        chk(cnt == 0, "R4 waits", cnt, 0);

        // R11: producer over a non-empty list pulses err_prod once.
        ins(0, 20, 20, 0, 1, 20, 1'b1);
        chk(err_prod, "R11 pulse", err_prod, 1);
        @(negedge clk);
        chk(!err_prod, "R11 one cycle", err_prod, 0);
        idle(3);

        // R7/R8: wake reg2 and reg1 together: tag7 then tag2.
        exp_q.push_back(7);
        exp_q.push_back(2);
        cmp(2, 1);
        chk(busy, "R5 busy", busy, 1);
        idle(8);

        // R6: completion naming only untracked registers.
        cmp(20, 31);
        chk(!busy, "R6 idle", busy, 0);
        @(negedge clk);
        chk(!busy, "R6 still idle", busy, 0);

        idle(5);
        chk(exp_q.size() == 0, "R7 all reported", exp_q.size(), 0);
        chk(!pool_low, "R10 pool recovered", pool_low, 0);
        summary();
        $finish;
    end
endmodule